// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the per-processor interrupt state for 256 vectors in three bitmaps: one for requested vectors, one for vectors in service, and one that records whether each requested vector was posted level-sensitive. Sources post a vector together with an edge/level flag. The processor side reads a pending flag and a processor-priority value, takes interrupts with an acknowledge strobe, and retires them with an end-of-interrupt strobe.

Every decision uses the priority class, which is the upper nibble of the vector. The processor priority is the larger of the task priority and the class of the highest vector in service. A request whose class does not exceed that priority is held back. An acknowledge that meets a held-back request returns the spurious vector and leaves all state unchanged. When a level-sensitive vector is retired, the block emits a one-cycle broadcast carrying that vector so that upstream sources can re-sample their lines.

Top module: `vic_prio_ctrl`

## Requirements
- R1: After a synchronous reset, all three bitmaps are empty, the task priority is 0x00, and the spurious register holds 0x0FF with its enable bit (bit 8) clear. `irq_pending`, `ppr`, `ack_valid` and `eoi_bcast` are therefore all 0.
- R2: A post sets the request bit of `post_vector`. The trigger bit is set when `post_level`=1 and cleared when `post_level`=0. A later edge post of the same vector therefore cancels the level-sensitive retirement broadcast.
- R3: The highest set vector number in a bitmap is its highest-priority entry, so acknowledges are served in descending vector order.
- R4: `ppr` equals the task priority when the task class (bits 7:4) is greater than or equal to the class of the highest in-service vector. Otherwise `ppr` equals that class followed by four zero bits. An empty in-service bitmap counts as class 0.
- R5: While spurious-register bit 8 is 0, `irq_pending` is 0 and an acknowledge returns nothing (`ack_valid` stays 0).
- R6: A request is blocked when `ppr` is nonzero and the class of the highest request is less than or equal to the class of `ppr`. A blocked request keeps `irq_pending` at 0. An acknowledge that meets it returns spurious-register bits 7:0 with `ack_spurious`=1 and leaves all state unchanged.
- R7: An acknowledge of an unblocked request clears the highest request bit and sets the matching in-service bit. One cycle later it presents that vector on `ack_vector` with `ack_valid`=1 and `ack_spurious`=0.
- R8: End-of-interrupt clears the highest in-service bit. If that vector's trigger bit is set and spurious-register bit 12 is 0, `eoi_bcast` pulses for one cycle with the vector on `eoi_vector`.
- R9: End-of-interrupt with an empty in-service bitmap changes nothing and produces no broadcast.
- R10: A spurious-register write stores only bits 8:0. Bit 12 written as 1 is discarded, so level-sensitive vectors still broadcast on retirement.
- R11: When a post and an acknowledge occur in the same cycle, the post is applied after the acknowledge, so a re-posted vector stays requested.
- R12: When an acknowledge and an end-of-interrupt occur in the same cycle, both use the state from before the edge. The end-of-interrupt retires the old highest in-service vector, and the acknowledge adds the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Post strobe |
| post_vector | input | 8 | Vector being posted |
| post_level | input | 1 | 1 = level-sensitive, 0 = edge |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write value |
| svr_we | input | 1 | Spurious-register write strobe |
| svr_wdata | input | 13 | Spurious-register write value |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | Unblocked request present and block enabled |
| ack_valid | output | 1 | One-cycle pulse: a vector is returned |
| ack_vector | output | 8 | Returned vector |
| ack_spurious | output | 1 | Returned vector is the spurious vector |
| ppr | output | 8 | Processor priority |
| eoi_bcast | output | 1 | One-cycle retirement broadcast for level vectors |
| eoi_vector | output | 8 | Vector carried by the broadcast |

## Verification
Two pairs of functions can fall on the same edge. The first pair is an acknowledge and a post of the vector being taken. The bench drives both strobes in the same cycle and then checks two things: the vector is returned, and it is still requested, which shows up as pending again once it is retired. The second pair is an acknowledge and an end-of-interrupt. The bench drives them together with a level vector in service and a higher request waiting. It expects the broadcast to carry the old in-service vector, the new vector to be returned, and `ppr` to follow the new in-service class.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int VEC_W      = 8;
    localparam int CLS_W      = 4;
    localparam int SUB_W      = VEC_W - CLS_W;
    localparam int NUM_VEC    = 1 << VEC_W;
    localparam int WORD_W     = 32;
    localparam int NUM_WORDS  = NUM_VEC / WORD_W;
    localparam int SVR_W      = 13;
    localparam int SVR_EN_BIT = 8;
    localparam int SVR_DE_BIT = 12;
    localparam logic [SVR_W-1:0] SVR_WMASK = 13'h01FF;
    localparam logic [SVR_W-1:0] SVR_RST   = 13'h00FF;

    typedef struct packed {
        logic             found;
        logic [VEC_W-1:0] vec;
    } scan_t;

    typedef struct packed {
        logic             valid;
        logic             spurious;
        logic [VEC_W-1:0] vec;
    } ack_rsp_t;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] vec;
    } bcast_t;

    function automatic logic [CLS_W-1:0] vclass(input logic [VEC_W-1:0] v);
        return v[VEC_W-1:SUB_W];
    endfunction
endpackage

// File: rtl/vic_msb_scan.sv
module vic_msb_scan #(
    parameter int NUM_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int WSEL_W   = $clog2(NUM_WORDS),
    localparam int IDX_W    = WSEL_W + BIT_W
) (
    input  logic [NUM_WORDS*WORD_W-1:0] bits,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);
    logic [NUM_WORDS-1:0]       w_any;
    logic [NUM_WORDS*BIT_W-1:0] w_idx;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [BIT_W-1:0] top_bit;
        always_comb begin
            top_bit = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W+b]) top_bit = BIT_W'(b);
            end
        end
        assign w_any[w] = |bits[w*WORD_W +: WORD_W];
        assign w_idx[w*BIT_W +: BIT_W] = top_bit;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (w_any[w]) begin
                found = 1'b1;
                idx   = {WSEL_W'(w), w_idx[w*BIT_W +: BIT_W]};
            end
        end
    end
endmodule

// File: rtl/vic_prio_eval.sv
module vic_prio_eval
    import vic_pkg::*;
(
    input  scan_t            irr_top,
    input  scan_t            isr_top,
    input  logic [VEC_W-1:0] tpr,
    input  logic             enable,
    output logic [VEC_W-1:0] ppr,
    output logic             pending,
    output logic             req_blocked
);
    logic [CLS_W-1:0] isr_cls;
    logic             blocked;

    always_comb begin
        isr_cls = isr_top.found ? vclass(isr_top.vec) : '0;
        if (vclass(tpr) >= isr_cls) ppr = tpr;
        else                        ppr = {isr_cls, {SUB_W{1'b0}}};
        blocked     = (ppr != '0) && (vclass(irr_top.vec) <= vclass(ppr));
        pending     = enable && irr_top.found && !blocked;
        req_blocked = enable && irr_top.found && blocked;
    end
endmodule

// File: rtl/vic_prio_ctrl.sv
module vic_prio_ctrl
    import vic_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int SW = SVR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          post_valid,
    input  logic [VW-1:0] post_vector,
    input  logic          post_level,
    input  logic          tpr_we,
    input  logic [VW-1:0] tpr_wdata,
    input  logic          svr_we,
    input  logic [SW-1:0] svr_wdata,
    input  logic          ack,
    input  logic          eoi,
    output logic          irq_pending,
    output logic          ack_valid,
    output logic [VW-1:0] ack_vector,
    output logic          ack_spurious,
    output logic [VW-1:0] ppr,
    output logic          eoi_bcast,
    output logic [VW-1:0] eoi_vector
);
    localparam int NV = 1 << VW;

    logic [NV-1:0] irr_q, isr_q, tmr_q;
    logic [NV-1:0] irr_n, isr_n, tmr_n;
    logic [VW-1:0] tpr_q;
    logic [SW-1:0] svr_q;
    scan_t         irr_top, isr_top;
    logic          req_blocked;
    logic          take, spur;
    ack_rsp_t      rsp_n, rsp_q;
    bcast_t        bc_n, bc_q;

    vic_msb_scan #(.NUM_WORDS(NV / WORD_W), .WORD_W(WORD_W)) u_irr_scan (
        .bits(irr_q), .found(irr_top.found), .idx(irr_top.vec)
    );
    vic_msb_scan #(.NUM_WORDS(NV / WORD_W), .WORD_W(WORD_W)) u_isr_scan (
        .bits(isr_q), .found(isr_top.found), .idx(isr_top.vec)
    );

    vic_prio_eval u_eval (
        .irr_top    (irr_top),
        .isr_top    (isr_top),
        .tpr        (tpr_q),
        .enable     (svr_q[SVR_EN_BIT]),
        .ppr        (ppr),
        .pending    (irq_pending),
        .req_blocked(req_blocked)
    );

    // Acknowledge outcome, decided from the pre-edge state
    assign take = ack && irq_pending;
    assign spur = ack && req_blocked;

    always_comb begin
        irr_n = irr_q;
        isr_n = isr_q;
        tmr_n = tmr_q;
        rsp_n = '0;
        bc_n  = '0;
        // retire first, then grant: both use the old scan results (R12)
        if (eoi && isr_top.found) begin
            isr_n[isr_top.vec] = 1'b0;
            if (tmr_q[isr_top.vec] && !svr_q[SVR_DE_BIT]) begin
                bc_n.valid = 1'b1;
                bc_n.vec   = isr_top.vec;
            end
        end
        if (take) begin
            irr_n[irr_top.vec] = 1'b0;
            isr_n[irr_top.vec] = 1'b1;
            rsp_n.valid = 1'b1;
            rsp_n.vec   = irr_top.vec;
        end else if (spur) begin
            rsp_n.valid    = 1'b1;
            rsp_n.spurious = 1'b1;
            rsp_n.vec      = svr_q[VW-1:0];
        end
        // post lands after the grant so a re-post survives (R11)
        if (post_valid) begin
            irr_n[post_vector] = 1'b1;
            tmr_n[post_vector] = post_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q <= '0;
            isr_q <= '0;
            tmr_q <= '0;
            tpr_q <= '0;
            svr_q <= SVR_RST;
            rsp_q <= '0;
            bc_q  <= '0;
        end else begin
            irr_q <= irr_n;
            isr_q <= isr_n;
            tmr_q <= tmr_n;
            rsp_q <= rsp_n;
            bc_q  <= bc_n;
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) svr_q <= svr_wdata & SVR_WMASK;
        end
    end

    assign ack_valid    = rsp_q.valid;
    assign ack_spurious = rsp_q.spurious;
    assign ack_vector   = rsp_q.vec;
    assign eoi_bcast    = bc_q.valid;
    assign eoi_vector   = bc_q.vec;
endmodule

// File: rtl/vic_prio_chk.sv
module vic_prio_chk
    import vic_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               post_valid,
    input logic [VEC_W-1:0]   post_vector,
    input logic               post_level,
    input logic               ack,
    input logic               eoi,
    input logic               irq_pending,
    input logic               ack_valid,
    input logic               ack_spurious,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               eoi_bcast,
    input logic [VEC_W-1:0]   ppr,
    input logic [VEC_W-1:0]   tpr_q,
    input logic [SVR_W-1:0]   svr_q,
    input logic [NUM_VEC-1:0] irr_q,
    input logic [NUM_VEC-1:0] isr_q,
    input logic [NUM_VEC-1:0] tmr_q
);
    assert_post_sets_req_R2: assert property (@(posedge clk) disable iff (rst)
        post_valid |=> irr_q[$past(post_vector)]);

    assert_post_trigger_R2: assert property (@(posedge clk) disable iff (rst)
        post_valid |=> (tmr_q[$past(post_vector)] == $past(post_level)));

    assert_ppr_floor_R4: assert property (@(posedge clk) disable iff (rst)
        vclass(ppr) >= vclass(tpr_q));

    assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !svr_q[SVR_EN_BIT] |-> !irq_pending);

    assert_grant_R7: assert property (@(posedge clk) disable iff (rst)
        (ack && irq_pending) |=> (ack_valid && !ack_spurious && isr_q[ack_vector]));

    assert_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_valid == 1'b0 && !irq_pending && (irr_q != '0) && svr_q[SVR_EN_BIT])
        |=> (ack_valid && ack_spurious && ack_vector == $past(svr_q[VEC_W-1:0])));

    assert_empty_eoi_R9: assert property (@(posedge clk) disable iff (rst)
        (eoi && isr_q == '0) |=> !eoi_bcast);

    assert_bcast_cause_R8: assert property (@(posedge clk) disable iff (rst)
        eoi_bcast |-> $past(eoi));

    assert_svr_mask_R10: assert property (@(posedge clk) disable iff (rst)
        !svr_q[SVR_DE_BIT]);
endmodule

bind vic_prio_ctrl vic_prio_chk u_chk (
    .clk(clk), .rst(rst), .post_valid(post_valid), .post_vector(post_vector),
    .post_level(post_level), .ack(ack), .eoi(eoi), .irq_pending(irq_pending),
    .ack_valid(ack_valid), .ack_spurious(ack_spurious), .ack_vector(ack_vector),
    .eoi_bcast(eoi_bcast), .ppr(ppr), .tpr_q(tpr_q), .svr_q(svr_q),
    .irr_q(irr_q), .isr_q(isr_q), .tmr_q(tmr_q)
);

// File: tb/test_vic_prio_ctrl.sv
module test_vic_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_valid = 1'b0;
    logic [7:0]  post_vector = '0;
    logic        post_level = 1'b0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [12:0] svr_wdata = '0;
    logic        ack = 1'b0;
    logic        eoi = 1'b0;
    logic        irq_pending, ack_valid, ack_spurious, eoi_bcast;
    logic [7:0]  ack_vector, ppr, eoi_vector;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    vic_prio_ctrl i_vic_prio_ctrl (
        .clk(clk), .rst(rst), .post_valid(post_valid), .post_vector(post_vector),
        .post_level(post_level), .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata), .ack(ack), .eoi(eoi),
        .irq_pending(irq_pending), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .ack_spurious(ack_spurious), .ppr(ppr), .eoi_bcast(eoi_bcast),
        .eoi_vector(eoi_vector)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic post(input logic [7:0] v, input logic lvl);
        @(negedge clk);
        post_valid = 1'b1; post_vector = v; post_level = lvl;
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        @(negedge clk); tpr_we = 1'b1; tpr_wdata = v;
        @(negedge clk); tpr_we = 1'b0;
    endtask

    task automatic wr_svr(input logic [12:0] v);
        @(negedge clk); svr_we = 1'b1; svr_wdata = v;
        @(negedge clk); svr_we = 1'b0;
    endtask

    task automatic do_ack(input string req, input logic val, input logic sp, input logic [7:0] v);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk(req, "ack_valid", int'(ack_valid), int'(val));
        if (val) begin
            chk(req, "ack_spurious", int'(ack_spurious), int'(sp));
            chk(req, "ack_vector", int'(ack_vector), int'(v));
        end
    endtask

    task automatic do_eoi(input string req, input logic bc, input logic [7:0] v);
        @(negedge clk); eoi = 1'b1;
        @(negedge clk); eoi = 1'b0;
        chk(req, "eoi_bcast", int'(eoi_bcast), int'(bc));
        if (bc) chk(req, "eoi_vector", int'(eoi_vector), int'(v));
    endtask

    task automatic t_reset_and_disabled();
        chk("R1", "irq_pending", int'(irq_pending), 0);
        chk("R1", "ppr", int'(ppr), 0);
        chk("R1", "ack_valid", int'(ack_valid), 0);
        chk("R1", "eoi_bcast", int'(eoi_bcast), 0);
        post(8'h40, 1'b0);
        chk("R5", "pending while disabled", int'(irq_pending), 0);
        do_ack("R5", 1'b0, 1'b0, 8'h00);
    endtask

    task automatic t_order();
        wr_svr(13'h11FF);  // bit 12 must be dropped (R10)
        chk("R10", "pending after enable", int'(irq_pending), 1);
        post(8'h31, 1'b0);
        post(8'h90, 1'b1);
        post(8'h45, 1'b0);
        do_ack("R3", 1'b1, 1'b0, 8'h90);
        chk("R4", "ppr from isr", int'(ppr), 8'h90);
        chk("R6", "blocked pending", int'(irq_pending), 0);
        do_ack("R6", 1'b1, 1'b1, 8'hFF);
        do_eoi("R10", 1'b1, 8'h90);
        chk("R8", "ppr after eoi", int'(ppr), 0);
        do_ack("R7", 1'b1, 1'b0, 8'h45);
        chk("R4", "ppr 0x40", int'(ppr), 8'h40);
        do_eoi("R8", 1'b0, 8'h00);
        do_ack("R3", 1'b1, 1'b0, 8'h40);
        do_eoi("R8", 1'b0, 8'h00);
        do_ack("R3", 1'b1, 1'b0, 8'h31);
        do_eoi("R8", 1'b0, 8'h00);
        chk("R7", "empty pending", int'(irq_pending), 0);
    endtask

    task automatic t_task_priority();
        wr_tpr(8'h55);
        chk("R4", "ppr=tpr", int'(ppr), 8'h55);
        post(8'h50, 1'b0);
        chk("R6", "equal class blocked", int'(irq_pending), 0);
        post(8'h61, 1'b0);
        chk("R6", "higher class pending", int'(irq_pending), 1);
        do_ack("R7", 1'b1, 1'b0, 8'h61);
        chk("R4", "isr class wins", int'(ppr), 8'h60);
        wr_tpr(8'h80);
        chk("R4", "tpr wins", int'(ppr), 8'h80);
        do_eoi("R8", 1'b0, 8'h00);
        do_eoi("R9", 1'b0, 8'h00);
        chk("R9", "ppr unchanged", int'(ppr), 8'h80);
        wr_tpr(8'h00);
        chk("R6", "unblocked by tpr", int'(irq_pending), 1);
        do_ack("R7", 1'b1, 1'b0, 8'h50);
        do_eoi("R8", 1'b0, 8'h00);
        wr_tpr(8'h03);
        post(8'h05, 1'b0);
        chk("R6", "class0 blocked by nonzero ppr", int'(irq_pending), 0);
        wr_tpr(8'h00);
        chk("R6", "class0 pending at ppr 0", int'(irq_pending), 1);
        do_ack("R7", 1'b1, 1'b0, 8'h05);
        chk("R4", "class0 isr ppr", int'(ppr), 0);
        do_eoi("R8", 1'b0, 8'h00);
    endtask

    task automatic t_post_with_ack();
        post(8'h70, 1'b0);
        @(negedge clk);
        ack = 1'b1; post_valid = 1'b1; post_vector = 8'h70; post_level = 1'b0;
        @(negedge clk);
        ack = 1'b0; post_valid = 1'b0;
        chk("R11", "ack_vector", int'(ack_vector), 8'h70);
        chk("R11", "blocked by own isr", int'(irq_pending), 0);
        do_eoi("R11", 1'b0, 8'h00);
        chk("R11", "re-post kept", int'(irq_pending), 1);
        do_ack("R11", 1'b1, 1'b0, 8'h70);
        do_eoi("R8", 1'b0, 8'h00);
    endtask

    task automatic t_ack_with_eoi();
        post(8'hA0, 1'b1);
        do_ack("R7", 1'b1, 1'b0, 8'hA0);
        post(8'hC2, 1'b0);
        @(negedge clk);
        ack = 1'b1; eoi = 1'b1;
        @(negedge clk);
        ack = 1'b0; eoi = 1'b0;
        chk("R12", "eoi_bcast", int'(eoi_bcast), 1);
        chk("R12", "eoi_vector", int'(eoi_vector), 8'hA0);
        chk("R12", "ack_vector", int'(ack_vector), 8'hC2);
        chk("R12", "ppr", int'(ppr), 8'hC0);
        do_eoi("R8", 1'b0, 8'h00);
        chk("R12", "ppr cleared", int'(ppr), 0);
    endtask

    task automatic t_trigger_override();
        post(8'h88, 1'b1);
        post(8'h88, 1'b0);
        do_ack("R2", 1'b1, 1'b0, 8'h88);
        do_eoi("R2", 1'b0, 8'h00);
        post(8'h89, 1'b1);
        do_ack("R2", 1'b1, 1'b0, 8'h89);
        do_eoi("R2", 1'b1, 8'h89);
    endtask

    task automatic t_disable_live();
        post(8'h22, 1'b0);
        chk("R5", "pending enabled", int'(irq_pending), 1);
        wr_svr(13'h00FF);
        chk("R5", "pending disabled", int'(irq_pending), 0);
        do_ack("R5", 1'b0, 1'b0, 8'h00);
        wr_svr(13'h01FF);
        do_ack("R5", 1'b1, 1'b0, 8'h22);
        do_eoi("R8", 1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_and_disabled();
        t_order();
        t_task_priority();
        t_post_with_ack();
        t_ack_with_eoi();
        t_trigger_override();
        t_disable_live();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule